// File: doc/BRIEF.md
# NoC Receive Depacketizer

This block sits between a network-on-chip input port and a small local processor. Flits arrive on a valid/ready input. The head flit of each packet is decoded into destination, packet type, tag and length. The body flits then go one of three ways. A single packet's one data word lands in a receive-data register. A block packet's words are written to local memory by a DMA engine, starting at an address the processor supplies. An instruction packet carries an opcode in its tag and an operand in its data word, and it updates the interface's own configuration registers without bothering the processor.

For single and block packets the block raises an interrupt. It holds its input ready low until the processor reads the receive-data register, so the network backs up instead of losing traffic. The processor side is a simple register port: read data follows the address in the same cycle, and reads and writes take effect at the clock edge. The memory side is a write-only port, also in the same cycle, for a synchronous SRAM.

Top module: `nocrx_depkt`

## Requirements
- R1: After reset, irq is low, in_ready is high, mem_we is low, and every readable register (addresses 0 to 7) returns zero.
- R2: A flit is 34 bits, with its kind in bits [33:32] (01 = head, 10 = body) and a 32-bit payload in [31:0]. While idle, only a head flit starts a packet; any other accepted flit is discarded and changes no register.
- R3: The head payload holds destination [31:24], packet type [23:20], tag [19:12] and length [11:0]. For single and block packets these read back at address 7 (destination), 1 (type), 0 (tag) and 2 (length).
- R4: For packet type 0, and for any type other than 1 and 15, the next accepted flit's payload is stored and reads back at address 3. irq goes high in the cycle after that flit is accepted.
- R5: While a packet waits for service, in_ready stays low. This covers single or block pending, and a block waiting for its address.
- R6: A read of address 3 while a single or block packet is pending drops irq and raises in_ready in the next cycle. Reads of other addresses, and a read of address 3 while a block waits for its address, change nothing.
- R7: For packet type 1 (block), irq goes high in the cycle after the head is accepted. in_ready stays low until the processor writes the start address to address 4.
- R8: Each body flit accepted during a block transfer drives mem_we high in the same cycle, with mem_wdata equal to the payload. mem_addr starts at the written address and rises by one per word, wrapping at the address width. Address 4 reads back the next write address.
- R9: When the number of words given by the length field has been stored, in_ready drops and the packet is pending. A length of zero goes to pending as soon as the address is written. Address 3 then reads back the last word stored, or zero if none was stored.
- R10: Packet type 15 is an instruction. Its body payload is written to configuration register A (address 5) for opcode 1, or to register B (address 6) for opcode 2. Any other opcode is ignored. No interrupt is raised, and the header registers keep their earlier contents.
- R11: A write to address 4 at any time other than a block waiting for its address is ignored, and the address readback stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit offered by the network |
| in_flit | input | 34 | Flit kind and payload |
| in_ready | output | 1 | Flit accepted when high together with in_valid |
| irq | output | 1 | Interrupt to the local processor |
| cpu_rd | input | 1 | Processor register read strobe |
| cpu_wr | input | 1 | Processor register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data, same cycle |
| mem_we | output | 1 | Local memory write enable |
| mem_addr | output | AW | Local memory word address |
| mem_wdata | output | 32 | Local memory write data |

## Verification
The bench builds the block with a 6-bit memory address. With that width, a block that starts at address 62 wraps through 63, 0 and 1 in only four words, so wrap-around is tested without long transfers. The length field keeps its full width. Blocks of four words and of zero words cover both the normal completion path and the path that goes straight to pending. Input gaps inside a block, stray body flits while idle, and register accesses at the wrong time are all included.

// File: rtl/nocrx_pkg.sv
package nocrx_pkg;

    localparam int PAY_W  = 32;
    localparam int KIND_W = 2;
    localparam int FLIT_W = KIND_W + PAY_W;

    localparam logic [KIND_W-1:0] KIND_HEAD = 2'b01;
    localparam logic [KIND_W-1:0] KIND_BODY = 2'b10;

    // head payload layout, most significant field first
    typedef struct packed {
        logic [7:0]  dest;
        logic [3:0]  ptype;
        logic [7:0]  tag;
        logic [11:0] len;
    } hdr_t;

    localparam int LEN_W = $bits(hdr_t) - 20;

    localparam logic [3:0] PT_BLOCK = 4'h1;
    localparam logic [3:0] PT_INSTR = 4'hF;

    localparam int NCFG = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SGL_DATA,
        ST_SGL_PEND,
        ST_BLK_WAIT,
        ST_BLK_DMA,
        ST_BLK_PEND,
        ST_INS_DATA
    } rx_state_e;

    localparam logic [2:0] RA_TAG   = 3'd0;
    localparam logic [2:0] RA_TYPE  = 3'd1;
    localparam logic [2:0] RA_LEN   = 3'd2;
    localparam logic [2:0] RA_DATA  = 3'd3;
    localparam logic [2:0] RA_WADDR = 3'd4;
    localparam logic [2:0] RA_CFGA  = 3'd5;
    localparam logic [2:0] RA_CFGB  = 3'd6;
    localparam logic [2:0] RA_DEST  = 3'd7;

endpackage

// File: rtl/nocrx_flit_ctl.sv
module nocrx_flit_ctl
    import nocrx_pkg::*;
(
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_flit,
    input  logic              take,
    input  logic              expect_body,
    output logic              head_fire,
    output logic              body_fire,
    output logic [PAY_W-1:0]  payload,
    output hdr_t              hdr
);

    logic              fire;
    logic [KIND_W-1:0] kind;

    always_comb begin
        fire      = in_valid && take;
        kind      = in_flit[FLIT_W-1 -: KIND_W];
        payload   = in_flit[PAY_W-1:0];
        hdr       = hdr_t'(in_flit[PAY_W-1:0]);
        // head only matters between packets; inside one every flit is data
        head_fire = fire && !expect_body && (kind == KIND_HEAD);
        body_fire = fire && expect_body;
    end

endmodule

// File: rtl/nocrx_dma.sv
module nocrx_dma
    import nocrx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    load_addr,
    input  logic [LEN_W-1:0] load_len,
    input  logic             beat,
    input  logic [PAY_W-1:0] beat_data,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [PAY_W-1:0] mem_wdata,
    output logic             last_beat,
    output logic [AW-1:0]    cur_addr
);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] rem;
    } dma_t;

    dma_t dma_d, dma_q;

    always_comb begin
        dma_d = dma_q;
        if (load) begin
            dma_d.addr = load_addr;
            dma_d.rem  = load_len;
        end else if (beat) begin
            dma_d.addr = dma_q.addr + 1'b1;
            dma_d.rem  = dma_q.rem - 1'b1;
        end
        mem_we    = beat;
        mem_addr  = dma_q.addr;
        mem_wdata = beat_data;
        last_beat = beat && (dma_q.rem == LEN_W'(1));
        cur_addr  = dma_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dma_q <= '0;
        else        dma_q <= dma_d;
    end

endmodule

// File: rtl/nocrx_cfg_regs.sv
module nocrx_cfg_regs
    import nocrx_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [7:0]                 op,
    input  logic [PAY_W-1:0]           operand,
    output logic [NREG-1:0][PAY_W-1:0] regs
);

    logic [NREG-1:0]            sel;
    logic [NREG-1:0][PAY_W-1:0] regs_d, regs_q;

    // opcode k+1 addresses register k; opcode 0 and out-of-range codes hit nothing
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = wr_en && (op == 8'(g + 1));
    end

    always_comb begin
        regs_d = regs_q;
        for (int k = 0; k < NREG; k++) begin
            if (sel[k]) regs_d[k] = operand;
        end
        regs = regs_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/nocrx_depkt.sv
module nocrx_depkt
    import nocrx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [33:0]       in_flit,
    output logic              in_ready,
    output logic              irq,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata
);

    typedef struct packed {
        rx_state_e        st;
        hdr_t             hdr;
        logic [PAY_W-1:0] data;
        logic [7:0]       op;
    } rx_t;

    rx_t s_d, s_q;

    logic                       expect_body;
    logic                       head_fire, body_fire;
    logic [PAY_W-1:0]           payload;
    hdr_t                       hdr_in;
    logic                       dma_load, dma_beat, dma_last;
    logic [AW-1:0]              dma_addr;
    logic                       cfg_wr;
    logic [NCFG-1:0][PAY_W-1:0] cfg;
    logic                       data_rd, addr_wr;

    nocrx_flit_ctl u_flit (
        .in_valid    (in_valid),
        .in_flit     (in_flit),
        .take        (in_ready),
        .expect_body (expect_body),
        .head_fire   (head_fire),
        .body_fire   (body_fire),
        .payload     (payload),
        .hdr         (hdr_in)
    );

    nocrx_dma #(.AW(AW)) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dma_load),
        .load_addr (cpu_wdata[AW-1:0]),
        .load_len  (s_q.hdr.len),
        .beat      (dma_beat),
        .beat_data (payload),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .last_beat (dma_last),
        .cur_addr  (dma_addr)
    );

    nocrx_cfg_regs #(.NREG(NCFG)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .op      (s_q.op),
        .operand (payload),
        .regs    (cfg)
    );

    // handshake and interrupt follow the state alone
    always_comb begin
        expect_body = (s_q.st == ST_SGL_DATA) || (s_q.st == ST_BLK_DMA) ||
                      (s_q.st == ST_INS_DATA);
        in_ready    = (s_q.st == ST_IDLE) || expect_body;
        irq         = (s_q.st == ST_SGL_PEND) || (s_q.st == ST_BLK_WAIT) ||
                      (s_q.st == ST_BLK_DMA)  || (s_q.st == ST_BLK_PEND);
        data_rd     = cpu_rd && (cpu_addr == RA_DATA) &&
                      ((s_q.st == ST_SGL_PEND) || (s_q.st == ST_BLK_PEND));
        addr_wr     = cpu_wr && (cpu_addr == RA_WADDR) && (s_q.st == ST_BLK_WAIT);
        dma_beat    = body_fire && (s_q.st == ST_BLK_DMA);
    end

    // packet sequencing
    always_comb begin
        s_d      = s_q;
        cfg_wr   = 1'b0;
        dma_load = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (head_fire) begin
                    if (hdr_in.ptype == PT_INSTR) begin
                        s_d.op = hdr_in.tag;
                        s_d.st = ST_INS_DATA;
                    end else begin
                        s_d.hdr  = hdr_in;
                        s_d.data = '0;
                        s_d.st   = (hdr_in.ptype == PT_BLOCK) ? ST_BLK_WAIT : ST_SGL_DATA;
                    end
                end
            end
            ST_SGL_DATA: begin
                if (body_fire) begin
                    s_d.data = payload;
                    s_d.st   = ST_SGL_PEND;
                end
            end
            ST_BLK_WAIT: begin
                if (addr_wr) begin
                    dma_load = 1'b1;
                    s_d.st   = (s_q.hdr.len == '0) ? ST_BLK_PEND : ST_BLK_DMA;
                end
            end
            ST_BLK_DMA: begin
                if (body_fire) begin
                    s_d.data = payload;
                    if (dma_last) s_d.st = ST_BLK_PEND;
                end
            end
            ST_INS_DATA: begin
                if (body_fire) begin
                    cfg_wr = 1'b1;
                    s_d.st = ST_IDLE;
                end
            end
            ST_SGL_PEND, ST_BLK_PEND: begin
                if (data_rd) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    // register read port
    always_comb begin
        case (cpu_addr)
            RA_TAG:   cpu_rdata = 32'(s_q.hdr.tag);
            RA_TYPE:  cpu_rdata = 32'(s_q.hdr.ptype);
            RA_LEN:   cpu_rdata = 32'(s_q.hdr.len);
            RA_DATA:  cpu_rdata = s_q.data;
            RA_WADDR: cpu_rdata = 32'(dma_addr);
            RA_CFGA:  cpu_rdata = cfg[0];
            RA_CFGB:  cpu_rdata = cfg[1];
            default:  cpu_rdata = 32'(s_q.hdr.dest);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

endmodule

// File: rtl/nocrx_depkt_chk.sv
module nocrx_depkt_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          irq,
    input logic          cpu_rd,
    input logic [2:0]    cpu_addr,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq && in_ready && !mem_we));

    // R8
    we_needs_flit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_valid && in_ready));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R6
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(cpu_rd && (cpu_addr == 3'd3)));

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(in_valid && in_ready));

    // R5
    no_write_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> !mem_we);

endmodule

bind nocrx_depkt nocrx_depkt_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .irq      (irq),
    .cpu_rd   (cpu_rd),
    .cpu_addr (cpu_addr),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/nocrx_depkt_test.sv
`timescale 1ns/1ps
module nocrx_depkt_test;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [33:0]   in_flit = '0;
    logic          in_ready;
    logic          irq;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [2:0]    cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic [31:0]   cpu_rdata;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;

    always #2 clk = ~clk;

    nocrx_depkt #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .irq(irq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference: phase names the step of the receive protocol
    // 0 between packets, 1 single awaiting word, 2 single waiting for cpu,
    // 3 block awaiting address, 4 block streaming, 5 block waiting for cpu,
    // 6 instruction awaiting operand
    int          phase;
    int          m_tag, m_type, m_len, m_dest, m_op;
    int          m_left;
    logic [31:0] m_data, m_cfga, m_cfgb;
    int          m_addr;

    function automatic logic [33:0] head(int dest, int pt, int tag, int len);
        return {2'b01, 8'(dest), 4'(pt), 8'(tag), 12'(len)};
    endfunction

    function automatic logic [33:0] body(logic [31:0] d);
        return {2'b10, d};
    endfunction

    task automatic model_reset();
        phase = 0; m_tag = 0; m_type = 0; m_len = 0; m_dest = 0; m_op = 0;
        m_left = 0; m_data = 0; m_cfga = 0; m_cfgb = 0; m_addr = 0;
    endtask

    task automatic fail_line(string req, string sig, logic [31:0] got, logic [31:0] exp);
        fails++;
        $display("FAIL %s %s got %h expected %h at %0t", req, sig, got, exp, $time);
    endtask

    // one clock: drive at falling edge, compare, advance the model
    task automatic cyc(input bit v, input logic [33:0] f, input bit rd, input bit wr,
                       input logic [2:0] a, input logic [31:0] wd, input string req);
        bit          e_ready, e_irq, e_we, acc;
        logic [31:0] e_rd;
        in_valid = v; in_flit = f; cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        #1;
        e_ready = (phase == 0) || (phase == 1) || (phase == 4) || (phase == 6);
        e_irq   = (phase >= 2) && (phase <= 5);
        e_we    = (phase == 4) && v;
        case (a)
            3'd0: e_rd = 32'(m_tag);
            3'd1: e_rd = 32'(m_type);
            3'd2: e_rd = 32'(m_len);
            3'd3: e_rd = m_data;
            3'd4: e_rd = 32'(m_addr);
            3'd5: e_rd = m_cfga;
            3'd6: e_rd = m_cfgb;
            default: e_rd = 32'(m_dest);
        endcase
        vectors++;
        if (in_ready !== e_ready) fail_line(req, "in_ready", 32'(in_ready), 32'(e_ready));
        if (irq !== e_irq)        fail_line(req, "irq", 32'(irq), 32'(e_irq));
        if (mem_we !== e_we)      fail_line(req, "mem_we", 32'(mem_we), 32'(e_we));
        if (e_we && (mem_addr !== AW'(m_addr)))
            fail_line(req, "mem_addr", 32'(mem_addr), 32'(m_addr));
        if (e_we && (mem_wdata !== f[31:0]))
            fail_line(req, "mem_wdata", mem_wdata, f[31:0]);
        if (cpu_rdata !== e_rd)   fail_line(req, "cpu_rdata", cpu_rdata, e_rd);
        acc = v && e_ready;
        case (phase)
            0: if (acc && f[33:32] == 2'b01) begin
                   if (f[23:20] == 4'hF) begin
                       m_op = int'(f[19:12]); phase = 6;
                   end else begin
                       m_dest = int'(f[31:24]); m_type = int'(f[23:20]);
                       m_tag = int'(f[19:12]); m_len = int'(f[11:0]); m_data = 0;
                       phase = (f[23:20] == 4'h1) ? 3 : 1;
                   end
               end
            1: if (acc) begin m_data = f[31:0]; phase = 2; end
            2, 5: if (rd && a == 3'd3) phase = 0;
            3: if (wr && a == 3'd4) begin
                   m_addr = int'(wd[AW-1:0]); m_left = m_len;
                   phase = (m_len == 0) ? 5 : 4;
               end
            4: if (acc) begin
                   m_data = f[31:0];
                   m_addr = (m_addr + 1) % (1 << AW);
                   m_left--;
                   if (m_left == 0) phase = 5;
               end
            6: if (acc) begin
                   if (m_op == 1) m_cfga = f[31:0];
                   else if (m_op == 2) m_cfgb = f[31:0];
                   phase = 0;
               end
            default: phase = 0;
        endcase
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        cyc(0, '0, 0, 0, 3'd0, '0, req);
    endtask

    task automatic rdreg(input logic [2:0] a, input string req);
        cyc(0, '0, 1, 0, a, '0, req);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values on every register
        for (int i = 0; i < 8; i++) rdreg(3'(i), "R1");

        // R2 stray body flit while idle is dropped
        cyc(1, body(32'h1111_2222), 0, 0, 3'd3, '0, "R2");
        rdreg(3'd3, "R2");

        // R11 address write while idle is ignored
        cyc(0, '0, 0, 1, 3'd4, 32'd9, "R11");
        rdreg(3'd4, "R11");

        // R4 single packet with the word arriving after a gap
        cyc(1, head(8'h5A, 0, 8'h33, 1), 0, 0, 3'd0, '0, "R4");
        idle("R4");
        cyc(1, body(32'hDEAD_BEEF), 0, 0, 3'd3, '0, "R4");
        // R5 offered flit held off while pending
        cyc(1, head(1, 0, 1, 1), 0, 0, 3'd3, '0, "R5");
        cyc(1, head(1, 0, 1, 1), 0, 0, 3'd3, '0, "R5");
        // R3 header fields
        for (int i = 0; i < 8; i++) rdreg(3'(i), "R3");
        // R6 read of another address keeps the packet pending
        rdreg(3'd0, "R6");
        rdreg(3'd3, "R6");
        idle("R6");

        // R10 instruction packets
        cyc(1, head(2, 15, 1, 1), 0, 0, 3'd5, '0, "R10");
        cyc(1, body(32'h1234_5678), 0, 0, 3'd5, '0, "R10");
        cyc(1, head(2, 15, 2, 1), 0, 0, 3'd6, '0, "R10");
        idle("R10");
        cyc(1, body(32'h0000_CAFE), 0, 0, 3'd6, '0, "R10");
        cyc(1, head(2, 15, 7, 1), 0, 0, 3'd5, '0, "R10");
        cyc(1, body(32'hFFFF_0000), 0, 0, 3'd6, '0, "R10");
        for (int i = 0; i < 8; i++) rdreg(3'(i), "R10");

        // R7 block packet waits for its address
        cyc(1, head(8'hC3, 1, 8'h44, 4), 0, 0, 3'd2, '0, "R7");
        cyc(1, body(32'hAAAA_0001), 0, 0, 3'd4, '0, "R7");
        rdreg(3'd3, "R6");
        cyc(0, '0, 0, 1, 3'd4, 32'd62, "R7");
        // R8 streaming with a gap, address wraps at the port width
        cyc(1, body(32'hA0A0_0000), 0, 0, 3'd4, '0, "R8");
        cyc(1, body(32'hA0A0_0001), 0, 0, 3'd4, '0, "R8");
        cyc(0, '0, 0, 0, 3'd4, '0, "R8");
        cyc(1, body(32'hA0A0_0002), 0, 0, 3'd4, '0, "R8");
        cyc(1, body(32'hA0A0_0003), 0, 0, 3'd3, '0, "R8");
        // R9 pending after the last word
        cyc(1, head(1, 0, 1, 1), 0, 0, 3'd3, '0, "R9");
        rdreg(3'd4, "R9");
        cyc(0, '0, 0, 1, 3'd4, 32'd5, "R11");
        rdreg(3'd4, "R11");
        rdreg(3'd3, "R9");
        idle("R9");

        // R9 zero-length block
        cyc(1, head(8'h0F, 1, 8'h55, 0), 0, 0, 3'd2, '0, "R9");
        cyc(0, '0, 0, 1, 3'd4, 32'd17, "R9");
        cyc(1, body(32'h7777_7777), 0, 0, 3'd3, '0, "R9");
        rdreg(3'd4, "R9");
        rdreg(3'd3, "R9");

        // R4 unlisted packet type handled as single
        cyc(1, head(8'h21, 5, 8'h66, 1), 0, 0, 3'd1, '0, "R4");
        cyc(1, body(32'h0BAD_F00D), 0, 0, 3'd3, '0, "R4");
        rdreg(3'd1, "R4");
        rdreg(3'd3, "R4");
        for (int i = 0; i < 4; i++) idle("R4");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule